// File: doc/BRIEF.md
# Chainable Serial Port-Configuration Receiver

This block is the serial front end of a general-purpose I/O expander. A host drives a four-wire serial bus (clock, active-low select, data in, data out). While select is low, the block shifts data-in bits into a 16-bit word on each rising serial clock. On each falling serial clock it drives the word's most significant bit onto data out. A bit therefore reappears on data out fifteen and a half serial clocks after it went in. This lets several identical devices share clock and select, with each data out wired to the next device's data in.

When select returns high, the block takes the word as it stands. The upper byte is a command and the lower byte is data. A write to one of seven configuration addresses updates four 2-bit port fields. Each field sets whether a port drives as an output, or is an input with or without pullup. A command with its top bit set asks for a register. The register's byte is placed in the low half of the word, so it shifts out during the next transaction. The serial pins are sampled with the system clock through synchronizers. All state lives in that one clock domain.

Top module: `gcr_top`

## Requirements
- R1: Data-in is shifted into the 16-bit word (new bit at bit 0) on a rising serial clock only while select is low. Clock and data activity while select is high leaves the word and all port settings unchanged.
- R2: Data out changes only on a falling serial clock while select is low, and then takes the word's bit 15. The bit shifted in on rising clock k therefore appears after falling clock k+15.
- R3: Data out is always driven to 0 or 1, including while select is high.
- R4: On the rising edge of select the whole word is taken at once. Bits 15..8 are the command and bits 7..0 the data, and the command acts once.
- R5: A write with command 0x09+g (g = 0..6) updates group g, which covers output bits 4g..4g+3 (bit 0 is the first port). Data bits 1:0 control bit 4g, and bits 7:6 control bit 4g+3.
- R6: Field code 01 makes a port an output (out-enable 1, pullup 0). Code 10 is an input without pullup (0,0). Code 11 is an input with pullup (0,1). Code 00 leaves that port's field unchanged.
- R7: Command 0x00, and any write command outside 0x09..0x0F, changes no port setting.
- R8: A command with bit 15 set reads the register at bits 14..8. Its byte (0x00 if out of range) replaces word bits 7..0, while bits 15..8 are kept. The byte then shows on data out after falling clocks 8..15 of the next transaction, bit 7 first. A read changes no port setting.
- R9: After reset every field is code 10 (all out-enables and pullups 0), the word is zero and data out is 0.
- R10: If select rises after a bit count that is not a multiple of 16, the command is the last 16 bits held in the word at that moment.
- R11: With n devices chained, one select-low window of 16·n clocks delivers the first word sent to the last device and the last word sent to the first device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, always driven |
| port_out_en | output | 4·NUM_GROUPS | Per-port output enable |
| port_pull_en | output | 4·NUM_GROUPS | Per-port pullup enable |

## Verification
The bench uses the default seven groups (28 ports) and a 16-bit word. Every group address is then a legal target, and reads just past the last group reach the out-of-range path. Three instances are chained so that echoed bits cross device boundaries, and the serial half-period of six system clocks leaves margin for the synchronizer latency. A behavioural model follows the first device clock by clock. Directed checks cover partial word counts, no-ops, activity while select is high, and read-back.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int FLD_W  = 2;
  localparam int FLDS_PER_GRP = BYTE_W / FLD_W;
  localparam logic [FLD_W-1:0] FLD_KEEP  = 2'b00;
  localparam logic [FLD_W-1:0] FLD_OUT   = 2'b01;
  localparam logic [FLD_W-1:0] FLD_IN    = 2'b10;
  localparam logic [FLD_W-1:0] FLD_IN_PU = 2'b11;
endpackage

// File: rtl/gcr_sync_edge.sv
module gcr_sync_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic chg
);
  logic s1_q, s2_q, s3_q;
  logic s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign lvl = s2_q;
  assign chg = s2_q ^ s3_q;
endmodule

// File: rtl/gcr_shifter.sv
module gcr_shifter
  import gcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdi,
  input  logic              out_en,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  output logic [WORD_W-1:0] word,
  output logic              sdo
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    sh_d  = sh_q;
    sdo_d = sdo_q;
    if (shift_en)
      sh_d = {sh_q[WORD_W-2:0], sdi};
    else if (load_en)
      sh_d = {sh_q[WORD_W-1:BYTE_W], load_byte};
    if (out_en)
      sdo_d = sh_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      sdo_q <= sdo_d;
    end
  end

  assign word = sh_q;
  assign sdo  = sdo_q;
endmodule

// File: rtl/gcr_cfg_regs.sv
module gcr_cfg_regs
  import gcr_pkg::*;
#(
  parameter int NUM_GROUPS = 7,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int NPORTS = NUM_GROUPS * FLDS_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [GRP_W-1:0]  rd_grp,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [NPORTS-1:0] out_en,
  output logic [NPORTS-1:0] pull_en
);
  logic [NPORTS-1:0][FLD_W-1:0] fld_q, fld_d;

  always_comb begin
    fld_d = fld_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int k = 0; k < FLDS_PER_GRP; k++) begin
        if (wr_en && (wr_grp == GRP_W'(g)) &&
            (wr_byte[FLD_W*k +: FLD_W] != FLD_KEEP))
          fld_d[FLDS_PER_GRP*g + k] = wr_byte[FLD_W*k +: FLD_W];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (rd_grp == GRP_W'(g)) begin
        for (int k = 0; k < FLDS_PER_GRP; k++)
          rd_byte[FLD_W*k +: FLD_W] = fld_q[FLDS_PER_GRP*g + k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORTS; i++) fld_q[i] <= FLD_IN;
    end else begin
      fld_q <= fld_d;
    end
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign out_en[i]  = (fld_q[i] == FLD_OUT);
    assign pull_en[i] = (fld_q[i] == FLD_IN_PU);

    assert_no_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fld_q[i] != FLD_KEEP);
  end

  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fld_q));
endmodule

// File: rtl/gcr_top.sv
module gcr_top
  import gcr_pkg::*;
#(
  parameter int NUM_GROUPS = 7,
  parameter int FIRST_ADDR = 9,
  localparam int NPORTS = NUM_GROUPS * FLDS_PER_GRP,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_cs_n,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic [NPORTS-1:0] port_out_en,
  output logic [NPORTS-1:0] port_pull_en
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic sclk_lvl, sclk_chg, cs_lvl, cs_chg;
  logic [1:0] din_q;

  gcr_sync_edge #(.RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_int_n), .d(ser_clk), .lvl(sclk_lvl), .chg(sclk_chg));
  gcr_sync_edge #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_int_n), .d(ser_cs_n), .lvl(cs_lvl), .chg(cs_chg));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) din_q <= '0;
    else            din_q <= {din_q[0], ser_din};
  end

  logic sclk_rise, sclk_fall, cs_low, cs_rise;
  assign sclk_rise = sclk_chg & sclk_lvl;
  assign sclk_fall = sclk_chg & ~sclk_lvl;
  assign cs_low    = ~cs_lvl;
  assign cs_rise   = cs_chg & cs_lvl;

  logic [WORD_W-1:0] word;
  logic [BYTE_W-1:0] cmd, data, rd_byte, ld_byte;
  logic [ADDR_W-1:0] addr, addr_off;
  logic              is_read, in_rng, wr_en, ld_en;

  always_comb begin
    cmd      = word[WORD_W-1:BYTE_W];
    data     = word[BYTE_W-1:0];
    is_read  = cmd[BYTE_W-1];
    addr     = cmd[ADDR_W-1:0];
    addr_off = addr - ADDR_W'(FIRST_ADDR);
    in_rng   = (addr >= ADDR_W'(FIRST_ADDR)) &&
               (addr < ADDR_W'(FIRST_ADDR + NUM_GROUPS));
    wr_en    = cs_rise && !is_read && in_rng;
    ld_en    = cs_rise && is_read;
    ld_byte  = in_rng ? rd_byte : '0;
  end

  gcr_shifter u_shift (
    .clk(clk), .rst_n(rst_int_n),
    .shift_en(sclk_rise & cs_low), .sdi(din_q[1]),
    .out_en(sclk_fall & cs_low),
    .load_en(ld_en), .load_byte(ld_byte),
    .word(word), .sdo(ser_dout));

  gcr_cfg_regs #(.NUM_GROUPS(NUM_GROUPS)) u_cfg (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_grp(addr_off[GRP_W-1:0]), .wr_byte(data),
    .rd_grp(addr_off[GRP_W-1:0]), .rd_byte(rd_byte),
    .out_en(port_out_en), .pull_en(port_pull_en));

  assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cs_low && !cs_rise) |=> $stable(word));

  assert_dout_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(sclk_fall && cs_low) |=> $stable(ser_dout));

  assert_dout_known_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$isunknown(ser_dout));

  assert_read_keeps_cmd_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_en |=> (word[WORD_W-1:BYTE_W] == $past(cmd)));

  assert_read_no_cfg_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_en |=> ($stable(port_out_en) && $stable(port_pull_en)));
endmodule

// File: tb/sim_gcr_top.sv
module sim_gcr_top;
  localparam int NG = 7;
  localparam int NP = NG * 4;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic sdo0, sdo1, sdo2;
  logic [NP-1:0] oe0, pu0, oe1, pu1, oe2, pu2;

  always #5 clk = ~clk;

  gcr_top u0 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_cs_n(cs_n),
    .ser_din(din), .ser_dout(sdo0), .port_out_en(oe0), .port_pull_en(pu0));
  gcr_top u1 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_cs_n(cs_n),
    .ser_din(sdo0), .ser_dout(sdo1), .port_out_en(oe1), .port_pull_en(pu1));
  gcr_top u2 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_cs_n(cs_n),
    .ser_din(sdo1), .ser_dout(sdo2), .port_out_en(oe2), .port_pull_en(pu2));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference for u0: pin history, then event rules
  logic hs[4], hc[4], hd[4];
  logic [15:0] m_sh;
  logic        m_sdo;
  int          m_fld[NP];

  initial for (int i = 0; i < 4; i++) begin hs[i] = 0; hc[i] = 1; hd[i] = 0; end

  always @(posedge clk) begin
    for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hc[i] = hc[i-1]; hd[i] = hd[i-1]; end
    hs[0] = sclk; hc[0] = cs_n; hd[0] = din;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      m_sh = '0; m_sdo = 1'b0;
      for (int i = 0; i < NP; i++) m_fld[i] = 2;
    end else begin
      bit rise, fall, low, csr;
      int a, g;
      rise = hs[2] && !hs[3];
      fall = !hs[2] && hs[3];
      low  = !hc[2];
      csr  = hc[2] && !hc[3];
      if (fall && low) m_sdo = m_sh[15];
      if (rise && low) m_sh = {m_sh[14:0], hd[2]};
      else if (csr) begin
        a = m_sh[14:8];
        g = a - 9;
        if (m_sh[15]) begin
          logic [7:0] b;
          b = '0;
          if (g >= 0 && g < NG)
            for (int k = 0; k < 4; k++) b[2*k +: 2] = m_fld[4*g+k][1:0];
          m_sh[7:0] = b;
        end else if (g >= 0 && g < NG) begin
          for (int k = 0; k < 4; k++)
            if (m_sh[2*k +: 2] != 2'b00) m_fld[4*g+k] = m_sh[2*k +: 2];
        end
      end
      begin
        logic [NP-1:0] eo, ep;
        for (int i = 0; i < NP; i++) begin
          eo[i] = (m_fld[i] == 1);
          ep[i] = (m_fld[i] == 3);
        end
        chk(sdo0 === m_sdo, "R2", "model sdo", 64'(sdo0), 64'(m_sdo));
        chk(oe0 === eo, "R5", "model out_en", 64'(oe0), 64'(eo));
        chk(pu0 === ep, "R6", "model pull_en", 64'(pu0), 64'(ep));
      end
    end
  end

  logic recv[1:64];

  task automatic xfer(input int nb, input logic [63:0] data);
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = nb - 1; i >= 0; i--) begin
      din = data[i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      recv[nb - i] = sdo0;
    end
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
    din = 1'b0;
  endtask

  function automatic logic [7:0] recv_byte();
    logic [7:0] b;
    for (int j = 8; j <= 15; j++) b[15 - j] = recv[j];
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] s_oe, s_pu, s_oe1, s_pu1, s_oe2, s_pu2;
    logic [15:0] w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R9 reset state
    chk(oe0 === '0, "R9", "reset out_en", 64'(oe0), 0);
    chk(pu0 === '0, "R9", "reset pull_en", 64'(pu0), 0);
    chk(sdo0 === 1'b0, "R9", "reset dout", 64'(sdo0), 0);
    xfer(16, 16'h8900);
    xfer(16, 16'h0000);
    chk(recv_byte() === 8'hAA, "R9", "reset read grp0", 64'(recv_byte()), 64'hAA);

    // R4 R5 R6 write group 0: fields 00,01,10,11 from bit pair 0 up
    xfer(16, 16'h09E4);
    chk(oe0[3:0] === 4'b0010, "R5", "grp0 out_en", 64'(oe0[3:0]), 4'b0010);
    chk(pu0[3:0] === 4'b1000, "R6", "grp0 pull_en", 64'(pu0[3:0]), 4'b1000);
    chk(oe0[NP-1:4] === '0, "R4", "other groups untouched", 64'(oe0[NP-1:4]), 0);

    // R8 read back and out-of-range read
    s_oe = oe0; s_pu = pu0;
    xfer(16, 16'h8900);
    chk(oe0 === s_oe && pu0 === s_pu, "R8", "read keeps ports", 64'(oe0), 64'(s_oe));
    xfer(16, 16'h0000);
    chk(recv_byte() === 8'hE6, "R8", "read grp0 byte", 64'(recv_byte()), 64'hE6);
    xfer(16, 16'h9000);
    xfer(16, 16'h0000);
    chk(recv_byte() === 8'h00, "R8", "out-of-range read", 64'(recv_byte()), 0);

    // R7 no-op and write outside range
    s_oe = oe0; s_pu = pu0;
    xfer(16, 16'h00FF);
    xfer(16, 16'h0555);
    xfer(16, 16'h10FF);
    chk(oe0 === s_oe, "R7", "no-op out_en", 64'(oe0), 64'(s_oe));
    chk(pu0 === s_pu, "R7", "no-op pull_en", 64'(pu0), 64'(s_pu));

    // R10 partial counts
    xfer(20, 64'hA0BFF);
    chk(pu0[11:8] === 4'hF, "R10", "20-bit frame", 64'(pu0[11:8]), 4'hF);
    xfer(24, 64'hFF0C01);
    chk(oe0[15:12] === 4'b0001, "R10", "24-bit frame", 64'(oe0[15:12]), 4'b0001);

    // R1 activity with select high
    xfer(16, 16'h0A55);
    s_oe = oe0; s_pu = pu0;
    for (int i = 0; i < 5; i++) begin
      din = 1'b1; repeat (H) @(negedge clk);
      sclk = 1'b1; repeat (H) @(negedge clk);
      sclk = 1'b0; repeat (H) @(negedge clk);
      chk(sdo0 === 1'b0 || sdo0 === 1'b1, "R3", "dout driven, select high", 64'(sdo0), 0);
    end
    din = 1'b0;
    chk(oe0 === s_oe && pu0 === s_pu, "R1", "ports after idle toggles", 64'(oe0), 64'(s_oe));
    xfer(16, 16'h0000);
    w = '0;
    for (int j = 1; j <= 15; j++) w[15 - j] = recv[j];
    chk(w[14:0] === 15'h0A55, "R1", "word after idle toggles", 64'(w[14:0]), 64'h0A55);

    // R2 echo delay
    xfer(32, {16'h1234, 16'h0000});
    w = '0;
    for (int j = 16; j <= 31; j++) w[31 - j] = recv[j];
    chk(w === 16'h1234, "R2", "echo after 15.5 clocks", 64'(w), 64'h1234);

    // R11 three-device chain: last device, no-op, first device
    s_oe1 = oe1; s_pu1 = pu1; s_oe2 = oe2; s_pu2 = pu2;
    xfer(48, {16'h0A55, 16'h0000, 16'h0FFF});
    chk(oe2[7:4] === 4'hF && pu2[7:4] === 4'h0, "R11", "chain dev2 write",
        64'({oe2[7:4], pu2[7:4]}), 64'hF0);
    chk(oe2[3:0] === s_oe2[3:0] && pu2[27:8] === s_pu2[27:8], "R11", "chain dev2 rest",
        64'(pu2), 64'(s_pu2));
    chk(oe1 === s_oe1 && pu1 === s_pu1, "R11", "chain dev1 no-op", 64'(pu1), 64'(s_pu1));
    chk(pu0[27:24] === 4'hF, "R11", "chain dev0 write", 64'(pu0[27:24]), 4'hF);
    chk(sdo0 === 1'b0 || sdo0 === 1'b1, "R3", "dout driven at end", 64'(sdo0), 0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule